// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block recovers asynchronous characters from a serial input line. Bit timing comes from a receive tick enable, a single-cycle pulse on the block clock, and the block runs at 1, 16 or 64 ticks per bit. It looks for a falling edge on an idle-high line. At the faster rates it confirms the start bit at its midpoint, then takes 5 to 8 data bits, least significant first, an optional parity bit and one stop bit. The character length, the parity setting and the tick rate are sampled from the format inputs when a start edge is seen. They stay fixed for the rest of that character.

Each finished character is offered on a valid/ready output stream. The serial line cannot be stalled, so back-pressure never delays reception. If a new character finishes while the previous one is still unaccepted, the new one replaces it and the overrun flag is raised. Parity, overrun and framing errors stay set until a one-cycle error-clear pulse. A separate break output shows a line held low for a whole character. The receiver only hunts for characters while its enable input is high.

Top module: `ser_async_rx`

## Requirements
- R1: At 16 or 64 ticks per bit, each data, parity and stop bit is sampled on the tick that lies a half bit plus a whole number of bits after the tick on which the line was first seen low. Data bits arrive least significant first.
- R2: `m_valid` rises on the cycle of the stop-bit sample. While `m_valid` is high and `m_ready` is low, `m_data` holds its value unless a new character completes. A cycle with both `m_valid` and `m_ready` high accepts the character and clears `m_valid`, unless another character completes in that same cycle.
- R3: Length code `len_sel` 00, 01, 10, 11 selects 5, 6, 7 or 8 data bits. The received bits sit at the bottom of `m_data` and the unused upper bits read as zero.
- R4: With `par_on` high, one parity bit follows the data. `par_even`=1 expects even parity over data plus parity bit, and `par_even`=0 expects odd parity. A mismatch sets `par_err`, and the character is still delivered.
- R5: A character that completes while `m_valid` is high and `m_ready` is low sets `ovr_err` and replaces `m_data`.
- R6: `par_err`, `ovr_err` and `frm_err` stay set until `err_clr` is high for a cycle, which clears all three. Accepting data does not clear them.
- R7: A stop bit sampled low sets `frm_err`. The receiver then waits for a high line sample before it hunts for a new start edge.
- R8: At 16 or 64 ticks per bit, a start edge whose line is high again at the start-bit midpoint is dropped. No character is delivered, and hunting resumes.
- R9: `brk_det` rises when every sample of a character, from start bit through stop bit, is low. It falls on the first later tick that samples the line high.
- R10: While `rx_en` is low, the receiver stays in its hunt state and delivers no character.
- R11: Rate code `rate_sel` 10 gives 16 ticks per bit and 11 gives 64. Codes 00 and 01 give one tick per bit: the start bit is taken on the first low sample, and every following tick samples the next bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_tick | input | 1 | Receive tick enable, one clock cycle wide |
| rx_en | input | 1 | Receiver enable |
| rxd_in | input | 1 | Serial line, already synchronous to `clk`, idle high |
| len_sel | input | 2 | Data length code (5 to 8 bits) |
| par_on | input | 1 | Parity bit present and checked |
| par_even | input | 1 | 1 selects even parity, 0 selects odd |
| rate_sel | input | 2 | Ticks per bit code |
| m_valid | output | 1 | Received character available |
| m_ready | input | 1 | Consumer accepts the character |
| m_data | output | 8 | Received character, zero-extended |
| err_clr | input | 1 | Clears the three error flags |
| par_err | output | 1 | Sticky parity error |
| ovr_err | output | 1 | Sticky overrun error |
| frm_err | output | 1 | Sticky framing error |
| brk_det | output | 1 | Line break present |

## Verification
Characters are sent at all three rates. At 64 ticks per bit the sample point is far from the bit edges, and one tick per bit leaves no margin at all, so errors in the counter limits show up differently at each rate. Lengths of 5, 7 and 8 bits with both parities, and deliberately wrong parity, separate a bit-count or shift-alignment fault from a parity-sense fault. A short low glitch, a low stop bit and a line held low separate the false-start, framing and break paths from each other. Two back-to-back characters without acceptance, and a character sent with the receiver disabled, show that the error flags stay set and that reception is gated by the enable.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;
  localparam int DATA_W  = 8;
  localparam int LEN_W   = 2;
  localparam int MIN_LEN = 5;
  localparam int LOG_MID = 4;            // 16 ticks per bit
  localparam int LOG_HI  = 6;            // 64 ticks per bit
  localparam int CNT_W   = LOG_HI;
  localparam int BITC_W  = $clog2(DATA_W + 1);

  typedef enum logic [2:0] {
    ST_HUNT, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_WAITHI
  } rx_state_e;

  function automatic logic [CNT_W-1:0] full_limit(input logic [1:0] rate);
    case (rate)
      2'b10:   full_limit = CNT_W'((1 << LOG_MID) - 1);
      2'b11:   full_limit = CNT_W'((1 << LOG_HI) - 1);
      default: full_limit = '0;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] half_limit(input logic [1:0] rate);
    case (rate)
      2'b10:   half_limit = CNT_W'((1 << (LOG_MID - 1)) - 1);
      2'b11:   half_limit = CNT_W'((1 << (LOG_HI - 1)) - 1);
      default: half_limit = '0;
    endcase
  endfunction
endpackage

// File: rtl/ser_rx_timer.sv
module ser_rx_timer
  import ser_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       restart,
  input  logic       half_sel,
  input  logic [1:0] rate,
  output logic       samp
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  always_comb lim = half_sel ? half_limit(rate) : full_limit(rate);

  assign samp = tick && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (tick)    cnt <= samp ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/ser_rx_frame.sv
module ser_rx_frame
  import ser_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_en,
  input  logic              rxd,
  input  logic [LEN_W-1:0]  len_sel,
  input  logic              par_on,
  input  logic              par_even,
  input  logic [1:0]        rate_sel,
  input  logic              samp,
  output logic              restart,
  output logic              half_sel,
  output logic [1:0]        rate_q,
  output logic              done,
  output logic [DATA_W-1:0] d_data,
  output logic              d_pe,
  output logic              d_fe,
  output logic              d_brk
);
  rx_state_e          state;
  logic [LEN_W-1:0]   len_q;
  logic               par_on_q;
  logic               par_even_q;
  logic [DATA_W-1:0]  shreg;
  logic [BITC_W-1:0]  bit_cnt;
  logic [BITC_W-1:0]  nbits;
  logic               par_acc;
  logic               par_bit;
  logic               all_low;
  logic               edge_seen;
  logic               slow_rate;

  assign slow_rate = (rate_sel[1] == 1'b0);
  assign edge_seen = rx_en && (state == ST_HUNT) && tick && !rxd;
  assign restart   = edge_seen || !rx_en;
  assign half_sel  = (state == ST_START);
  assign nbits     = BITC_W'(MIN_LEN) + BITC_W'(len_q);

  assign done   = rx_en && (state == ST_STOP) && samp;
  assign d_data = shreg >> (BITC_W'(DATA_W) - nbits);
  assign d_pe   = par_on_q && (par_acc ^ par_bit ^ !par_even_q);
  assign d_fe   = !rxd;
  assign d_brk  = all_low && !rxd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_HUNT;
      len_q      <= '0;
      par_on_q   <= 1'b0;
      par_even_q <= 1'b0;
      rate_q     <= 2'b00;
      shreg      <= '0;
      bit_cnt    <= '0;
      par_acc    <= 1'b0;
      par_bit    <= 1'b0;
      all_low    <= 1'b0;
    end else if (!rx_en) begin
      state <= ST_HUNT;
    end else begin
      case (state)
        ST_HUNT: if (edge_seen) begin
          len_q      <= len_sel;
          par_on_q   <= par_on;
          par_even_q <= par_even;
          rate_q     <= rate_sel;
          shreg      <= '0;
          bit_cnt    <= '0;
          par_acc    <= 1'b0;
          par_bit    <= 1'b0;
          all_low    <= 1'b1;
          state      <= slow_rate ? ST_DATA : ST_START;
        end
        ST_START: if (samp) state <= rxd ? ST_HUNT : ST_DATA;
        ST_DATA: if (samp) begin
          shreg   <= {rxd, shreg[DATA_W-1:1]};
          par_acc <= par_acc ^ rxd;
          all_low <= all_low && !rxd;
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == nbits - 1'b1) state <= par_on_q ? ST_PAR : ST_STOP;
        end
        ST_PAR: if (samp) begin
          par_bit <= rxd;
          all_low <= all_low && !rxd;
          state   <= ST_STOP;
        end
        ST_STOP: if (samp) state <= rxd ? ST_HUNT : ST_WAITHI;
        ST_WAITHI: if (tick && rxd) state <= ST_HUNT;
        default: state <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/ser_rx_flags.sv
module ser_rx_flags
  import ser_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              done,
  input  logic [DATA_W-1:0] d_data,
  input  logic              d_pe,
  input  logic              d_fe,
  input  logic              d_brk,
  input  logic              m_ready,
  input  logic              err_clr,
  output logic              m_valid,
  output logic [DATA_W-1:0] m_data,
  output logic              par_err,
  output logic              ovr_err,
  output logic              frm_err,
  output logic              brk_det
);
  logic overrun;
  assign overrun = done && m_valid && !m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (done) begin
      m_valid <= 1'b1;
      m_data  <= d_data;
    end else if (m_valid && m_ready) begin
      m_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_err <= 1'b0;
      ovr_err <= 1'b0;
      frm_err <= 1'b0;
    end else begin
      par_err <= (done && d_pe) || (par_err && !err_clr);
      ovr_err <= overrun        || (ovr_err && !err_clr);
      frm_err <= (done && d_fe) || (frm_err && !err_clr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               brk_det <= 1'b0;
    else if (done && d_brk)   brk_det <= 1'b1;
    else if (tick && rxd)     brk_det <= 1'b0;
  end
endmodule

// File: rtl/ser_async_rx.sv
module ser_async_rx
  import ser_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_tick,
  input  logic              rx_en,
  input  logic              rxd_in,
  input  logic [LEN_W-1:0]  len_sel,
  input  logic              par_on,
  input  logic              par_even,
  input  logic [1:0]        rate_sel,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  input  logic              err_clr,
  output logic              par_err,
  output logic              ovr_err,
  output logic              frm_err,
  output logic              brk_det
);
  logic              samp, restart, half_sel, done;
  logic              d_pe, d_fe, d_brk;
  logic [1:0]        rate_q;
  logic [DATA_W-1:0] d_data;

  ser_rx_timer u_timer (
    .clk(clk), .rst_n(rst_n), .tick(rx_tick), .restart(restart),
    .half_sel(half_sel), .rate(rate_q), .samp(samp)
  );

  ser_rx_frame u_frame (
    .clk(clk), .rst_n(rst_n), .tick(rx_tick), .rx_en(rx_en), .rxd(rxd_in),
    .len_sel(len_sel), .par_on(par_on), .par_even(par_even),
    .rate_sel(rate_sel), .samp(samp), .restart(restart),
    .half_sel(half_sel), .rate_q(rate_q), .done(done), .d_data(d_data),
    .d_pe(d_pe), .d_fe(d_fe), .d_brk(d_brk)
  );

  ser_rx_flags u_flags (
    .clk(clk), .rst_n(rst_n), .tick(rx_tick), .rxd(rxd_in), .done(done),
    .d_data(d_data), .d_pe(d_pe), .d_fe(d_fe), .d_brk(d_brk),
    .m_ready(m_ready), .err_clr(err_clr), .m_valid(m_valid),
    .m_data(m_data), .par_err(par_err), .ovr_err(ovr_err),
    .frm_err(frm_err), .brk_det(brk_det)
  );
endmodule

// File: rtl/ser_async_rx_chk.sv
module ser_async_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_tick,
  input logic       rx_en,
  input logic       rxd_in,
  input logic       m_valid,
  input logic       m_ready,
  input logic [7:0] m_data,
  input logic       err_clr,
  input logic       par_err,
  input logic       ovr_err,
  input logic       frm_err,
  input logic       brk_det
);
  // characters only complete on a tick, so tick-free cycles isolate handshake rules
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready && !rx_tick |=> m_valid && $stable(m_data));
  assert_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready && !rx_tick |=> !m_valid);
  assert_sticky_pe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    par_err && !err_clr |=> par_err);
  assert_sticky_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_err && !err_clr |=> ovr_err);
  assert_sticky_fe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frm_err && !err_clr |=> frm_err);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr && !rx_tick |=> !par_err && !ovr_err && !frm_err);
  assert_brk_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_tick && rxd_in |=> !brk_det);
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en && !m_valid |=> !m_valid);
endmodule

bind ser_async_rx ser_async_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rx_en(rx_en),
  .rxd_in(rxd_in), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
  .err_clr(err_clr), .par_err(par_err), .ovr_err(ovr_err),
  .frm_err(frm_err), .brk_det(brk_det)
);

// File: tb/ser_async_rx_tb_top.sv
module ser_async_rx_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_tick = 1'b0, rx_en = 1'b1, rxd_in = 1'b1;
  logic [1:0] len_sel = 2'b11, rate_sel = 2'b10;
  logic       par_on = 1'b0, par_even = 1'b0;
  logic       m_valid, m_ready = 1'b0, err_clr = 1'b0;
  logic [7:0] m_data;
  logic       par_err, ovr_err, frm_err, brk_det;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_async_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rx_en(rx_en),
    .rxd_in(rxd_in), .len_sel(len_sel), .par_on(par_on),
    .par_even(par_even), .rate_sel(rate_sel), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data), .err_clr(err_clr),
    .par_err(par_err), .ovr_err(ovr_err), .frm_err(frm_err),
    .brk_det(brk_det)
  );

  task automatic check(input string req, input string what,
                       input int actual, input int expected);
    n_cmp++;
    if (actual != expected) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) rx_tick = 1'b1;
      @(negedge clk) rx_tick = 1'b0;
    end
  endtask

  function automatic int rate_ticks(input logic [1:0] r);
    return (r == 2'b10) ? 16 : (r == 2'b11) ? 64 : 1;
  endfunction

  task automatic set_fmt(input logic [1:0] l, input logic p, input logic e,
                         input logic [1:0] r);
    len_sel = l; par_on = p; par_even = e; rate_sel = r;
  endtask

  // one character on the line; bad_par flips the parity bit, stop_v sets the stop level
  task automatic send(input logic [7:0] d, input bit bad_par, input logic stop_v);
    int nb = 5 + int'(len_sel);
    int f  = rate_ticks(rate_sel);
    logic p = 1'b0;
    rxd_in = 1'b0; ticks(f);
    for (int i = 0; i < nb; i++) begin
      rxd_in = d[i]; p ^= d[i]; ticks(f);
    end
    if (par_on) begin
      rxd_in = (par_even ? p : ~p) ^ bad_par; ticks(f);
    end
    rxd_in = stop_v; ticks(f);
    rxd_in = 1'b1; ticks(2);
  endtask

  task automatic accept();
    @(negedge clk) m_ready = 1'b1;
    @(negedge clk) m_ready = 1'b0;
  endtask

  task automatic clear_errs();
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R2", "valid after reset", m_valid, 0);
    check("R6", "flags after reset", {par_err, ovr_err, frm_err}, 0);
    check("R9", "break after reset", brk_det, 0);
  endtask

  task automatic t_basic_x16();
    set_fmt(2'b11, 1'b0, 1'b0, 2'b10);
    send(8'hA5, 0, 1'b1);
    check("R1", "x16 valid", m_valid, 1);
    check("R1", "x16 data", m_data, 8'hA5);
    ticks(3);
    check("R2", "data held without ready", m_data, 8'hA5);
    accept();
    check("R2", "valid after accept", m_valid, 0);
  endtask

  task automatic t_short_x64();
    set_fmt(2'b00, 1'b1, 1'b1, 2'b11);
    send(8'hF3, 0, 1'b1);
    check("R3", "5-bit data zero-extended", m_data, 8'h13);
    check("R4", "even parity ok", par_err, 0);
    accept();
  endtask

  task automatic t_parity_err();
    set_fmt(2'b10, 1'b1, 1'b0, 2'b10);
    send(8'h2B, 1, 1'b1);
    check("R4", "odd parity mismatch flag", par_err, 1);
    check("R4", "char still delivered", m_data, 8'h2B);
    accept();
    check("R6", "parity flag survives accept", par_err, 1);
    clear_errs();
    check("R6", "parity flag after clear", par_err, 0);
  endtask

  task automatic t_overrun();
    set_fmt(2'b11, 1'b0, 1'b0, 2'b10);
    send(8'h11, 0, 1'b1);
    send(8'h22, 0, 1'b1);
    check("R5", "overrun flag", ovr_err, 1);
    check("R5", "newer char kept", m_data, 8'h22);
    accept();
    ticks(2);
    check("R6", "overrun sticky", ovr_err, 1);
    clear_errs();
    check("R6", "overrun cleared", ovr_err, 0);
  endtask

  task automatic t_framing();
    set_fmt(2'b11, 1'b0, 1'b0, 2'b10);
    send(8'h55, 0, 1'b0);
    check("R7", "framing flag", frm_err, 1);
    check("R9", "no break for nonzero char", brk_det, 0);
    accept();
    clear_errs();
    send(8'h96, 0, 1'b1);
    check("R7", "next char after framing error", m_data, 8'h96);
    check("R7", "no new framing error", frm_err, 0);
    accept();
  endtask

  task automatic t_false_start();
    set_fmt(2'b11, 1'b0, 1'b0, 2'b10);
    rxd_in = 1'b0; ticks(4);
    rxd_in = 1'b1; ticks(40);
    check("R8", "glitch delivers nothing", m_valid, 0);
    send(8'h3C, 0, 1'b1);
    check("R8", "hunt resumed after glitch", m_data, 8'h3C);
    check("R8", "char valid after glitch", m_valid, 1);
    accept();
  endtask

  task automatic t_break();
    set_fmt(2'b11, 1'b0, 1'b0, 2'b10);
    rxd_in = 1'b0; ticks(16 * 12);
    check("R9", "break raised", brk_det, 1);
    check("R7", "break also framing error", frm_err, 1);
    check("R9", "break char data", m_data, 0);
    rxd_in = 1'b1; ticks(1);
    check("R9", "break drops on high line", brk_det, 0);
    accept();
    clear_errs();
  endtask

  task automatic t_disabled();
    set_fmt(2'b11, 1'b0, 1'b0, 2'b10);
    rx_en = 1'b0;
    send(8'h7E, 0, 1'b1);
    check("R10", "no char while disabled", m_valid, 0);
    rx_en = 1'b1; ticks(2);
    send(8'h81, 0, 1'b1);
    check("R10", "char after enable", m_data, 8'h81);
    accept();
  endtask

  task automatic t_x1();
    set_fmt(2'b11, 1'b1, 1'b1, 2'b01);
    send(8'hC6, 0, 1'b1);
    check("R11", "x1 data", m_data, 8'hC6);
    check("R11", "x1 parity ok", par_err, 0);
    accept();
    set_fmt(2'b01, 1'b0, 1'b0, 2'b00);
    send(8'hED, 0, 1'b1);
    check("R11", "code 00 six-bit data", m_data, 8'h2D);
    accept();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_x16();
    t_short_x64();
    t_parity_err();
    t_overrun();
    t_framing();
    t_false_start();
    t_break();
    t_disabled();
    t_x1();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule